// File: doc/BRIEF.md
# Standard-mode two-wire bus master

This block is a controller that owns a two-wire open-drain serial bus (one clock line, one data line) and runs it at up to 100 kHz. A host gives it one command at a time: put a START on the bus, send a byte, fetch a byte and answer it with ACK or NACK, or end the transfer with a STOP. A START given while the master already holds the bus becomes a repeated START. After each command the block pulses `done`. For a sent byte it reports whether the slave acknowledged. For a fetched byte it returns the data.

The block never drives either line high. It drives each line only through an output enable: 1 pulls the line low and 0 releases it to the pull-up. Each timing minimum has its own cycle count, derived from the system clock frequency parameter with ceiling rounding, and that count holds the matching bus phase. These minimums are the clock low time, clock high time, START hold, repeated-START setup, STOP setup, bus-free time and data setup. Between commands SCL stays low, so the bus remains claimed. Slave clock stretching, arbitration and 10-bit addressing are not handled.

Top module: `twb_master`

## Requirements
- R1: After reset, and whenever the bus is free, `scl_oe` and `sda_oe` are 0, `busy` is 0 and `done` is 0.
- R2: A START (command code 0) from the free bus pulls SDA low while SCL is released. SCL is pulled low no sooner than the START-hold count (ceil of 4.0 µs). The command then completes with both lines held low.
- R3: Every SCL low period lasts at least the low count. Every SCL high period lasts at least the high count.
- R4: The master changes SDA only while SCL is low, except for START and STOP edges. SDA never changes in the same cycle as SCL.
- R5: A write (code 2) sends `wr_data` most significant bit first, a pulled line meaning 0. The master releases SDA on the ninth clock. `ack_out` becomes 1 if SDA was sampled low on that clock, and 0 if it was sampled high.
- R6: A read (code 3) releases SDA for eight clocks and shifts the sampled bits into `rd_data`, most significant bit first. On the ninth clock SDA is pulled low when `rd_nack` is 0 and left released when it is 1.
- R7: A START given while the master holds the bus first releases SDA with SCL low. It then releases SCL and keeps SCL high for at least the repeated-START setup count (ceil of 4.7 µs) before SDA falls.
- R8: A STOP (code 1) pulls SDA low while SCL is low, then releases SCL for at least the STOP-setup count (ceil of 4.7 µs), then releases SDA. It signals `done` only after the bus-free count (ceil of 4.7 µs) has elapsed.
- R9: `done` is a one-cycle pulse at the end of each command. `busy` is 1 while a command runs, and a command presented while `busy` is 1 has no effect.
- R10: Write, read and STOP commands presented while the bus is free are ignored: no `done`, and both enables stay 0.
- R11: Counts are ceil(t × SYS_CLK_HZ / 1e9) with a minimum of 1. The high count uses 4.0 µs. The low count is the largest of: ceil(4.7 µs), the ceil of the 10 µs period minus the high count, and the data-setup count (ceil of 250 ns) plus one. The low count is exact for bits inside a byte, and so is the high count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd | input | 2 | 0 START, 1 STOP, 2 write, 3 read |
| wr_data | input | 8 | Byte for a write command |
| rd_nack | input | 1 | Ninth bit sent after a read: 0 ACK, 1 NACK |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| ack_out | output | 1 | 1 if the slave acknowledged the last written byte |
| rd_data | output | 8 | Last byte read |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with a 2 MHz system clock. At that rate the counts come to 12 low, 8 high, 8 START hold, 10 for each 4.7 µs minimum and 1 for data setup. Two of these depend on the rounding: 9.4 and 0.5 cycles round up. The low count of 12 comes from the 100 kHz period rule and not from the 4.7 µs minimum. Because every phase stays short, dozens of random transactions with mixed reads, writes, repeated STARTs and slave NACKs fit in the run. A bus monitor measures every phase exactly against these numbers.

// File: rtl/twb_master.sv
module twb_master #(
  parameter int unsigned SYS_CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic [7:0] wr_data,
  input  logic       rd_nack,
  output logic       busy,
  output logic       done,
  output logic       ack_out,
  output logic [7:0] rd_data,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);

  function automatic int unsigned cyc(input longint unsigned ns);
    longint unsigned c;
    c = (ns * longint'(SYS_CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  localparam int unsigned HIGH_C  = cyc(4000);
  localparam int unsigned SUDAT_C = cyc(250);
  localparam int unsigned LOW_A   = cyc(4700);
  localparam int unsigned LOW_B   = (cyc(10000) > HIGH_C) ? cyc(10000) - HIGH_C : 1;
  localparam int unsigned LOW_AB  = (LOW_A > LOW_B) ? LOW_A : LOW_B;
  localparam int unsigned LOW_C   = (LOW_AB > SUDAT_C) ? LOW_AB : SUDAT_C + 1;
  localparam int unsigned HDSTA_C = cyc(4000);
  localparam int unsigned SUSTA_C = cyc(4700);
  localparam int unsigned SUSTO_C = cyc(4700);
  localparam int unsigned BUF_C   = cyc(4700);
  localparam int unsigned MAX_C   = (LOW_C > SUSTA_C) ? LOW_C : SUSTA_C;
  localparam int unsigned CW      = $clog2(MAX_C + 1);

  localparam logic [1:0] C_START = 2'd0;
  localparam logic [1:0] C_STOP  = 2'd1;
  localparam logic [1:0] C_WRITE = 2'd2;

  typedef enum logic [3:0] {
    S_FREE, S_STA_HD, S_HOLD, S_BLO, S_BHI,
    S_RS_LO, S_RS_HI, S_SP_LO, S_SP_HI, S_SP_BUF
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic          is_rd, mnack;
  logic [1:0]    sync;
  logic          lo_sda;

  wire smp       = sync[1];
  wire last      = (cnt == '0);
  wire first_low = (cnt == CW'(LOW_C - 1));

  assign busy = !(st == S_FREE || st == S_HOLD);

  always_comb begin
    case (st)
      S_BLO:   lo_sda = (bitn == 4'd8) ? (is_rd & ~mnack) : (~is_rd & ~sh[7]);
      S_SP_LO: lo_sda = 1'b1;
      default: lo_sda = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_FREE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      mnack   <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      done    <= 1'b0;
      ack_out <= 1'b0;
      rd_data <= '0;
      sync    <= 2'b11;
    end else begin
      done <= 1'b0;
      sync <= {sync[0], sda_in};
      if (!last) cnt <= cnt - 1'b1;
      case (st)
        S_FREE:
          if (cmd_valid && cmd == C_START) begin
            sda_oe <= 1'b1;
            cnt    <= CW'(HDSTA_C - 1);
            st     <= S_STA_HD;
          end
        S_STA_HD:
          if (last) begin
            scl_oe <= 1'b1;
            done   <= 1'b1;
            st     <= S_HOLD;
          end
        S_HOLD:
          if (cmd_valid) begin
            cnt  <= CW'(LOW_C - 1);
            bitn <= '0;
            case (cmd)
              C_START: st <= S_RS_LO;
              C_STOP:  st <= S_SP_LO;
              C_WRITE: begin
                sh    <= wr_data;
                is_rd <= 1'b0;
                st    <= S_BLO;
              end
              default: begin
                is_rd <= 1'b1;
                mnack <= rd_nack;
                st    <= S_BLO;
              end
            endcase
          end
        S_BLO, S_RS_LO, S_SP_LO: begin
          if (first_low) sda_oe <= lo_sda;
          if (last) begin
            scl_oe <= 1'b0;
            case (st)
              S_BLO:   begin cnt <= CW'(HIGH_C - 1);  st <= S_BHI;   end
              S_RS_LO: begin cnt <= CW'(SUSTA_C - 1); st <= S_RS_HI; end
              default: begin cnt <= CW'(SUSTO_C - 1); st <= S_SP_HI; end
            endcase
          end
        end
        S_BHI:
          if (last) begin
            scl_oe <= 1'b1;
            cnt    <= CW'(LOW_C - 1);
            if (bitn != 4'd8) begin
              sh   <= {sh[6:0], smp};
              bitn <= bitn + 1'b1;
              st   <= S_BLO;
            end else begin
              if (is_rd) rd_data <= sh;
              else       ack_out <= ~smp;
              done <= 1'b1;
              st   <= S_HOLD;
            end
          end
        S_RS_HI:
          if (last) begin
            sda_oe <= 1'b1;
            cnt    <= CW'(HDSTA_C - 1);
            st     <= S_STA_HD;
          end
        S_SP_HI:
          if (last) begin
            sda_oe <= 1'b0;
            cnt    <= CW'(BUF_C - 1);
            st     <= S_SP_BUF;
          end
        S_SP_BUF:
          if (last) begin
            done <= 1'b1;
            st   <= S_FREE;
          end
        default: st <= S_FREE;
      endcase
    end
  end

  logic [15:0] lo_run, hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= scl_oe ? ((lo_run == 16'hffff) ? lo_run : lo_run + 1'b1) : '0;
      hi_run <= scl_oe ? '0 : ((hi_run == 16'hffff) ? hi_run : hi_run + 1'b1);
    end
  end

  // R1
  free_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FREE) |-> (!scl_oe && !sda_oe && !busy));

  // R3
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> (lo_run >= 16'(LOW_C)));

  // R3
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (hi_run >= 16'(HIGH_C)));

  // R4
  sda_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $stable(scl_oe));

  // R4
  sda_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe) |-> (st == S_STA_HD || st == S_SP_BUF));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/twb_master_bench.sv
module twb_master_bench;
  localparam int unsigned HZ = 2_000_000;
  localparam int CLK_P = 10;

  function automatic int need(input longint ns);
    longint c;
    c = (ns * longint'(HZ) + 999_999_999) / 1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int low_need();
    int a, b, s;
    a = need(4700);
    b = need(10000) - need(4000);
    s = need(250) + 1;
    if (b > a) a = b;
    if (s > a) a = s;
    return a;
  endfunction

  localparam int E_HIGH = need(4000);
  localparam int E_LOW  = low_need();
  localparam int E_HD   = need(4000);
  localparam int E_SU47 = need(4700);

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic       cmd_valid = 1'b0, rd_nack = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       busy, done, ack_out, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic       pull, scl, sda;

  assign scl = ~scl_oe;
  assign sda = ~sda_oe & ~pull;

  twb_master #(.SYS_CLK_HZ(HZ)) u_twb_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .wr_data(wr_data), .rd_nack(rd_nack), .busy(busy), .done(done),
    .ack_out(ack_out), .rd_data(rd_data), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda)
  );

  int errs = 0, checks = 0;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_ge(input string r, input int act, input int mn);
    checks++;
    if (act < mn) begin
      errs++;
      $display("FAIL %s actual=%0d expected>=%0d", r, act, mn);
    end
  endtask

  // slave model
  int       smode = 0;
  logic [7:0] stx = 8'd0, srx = 8'd0;
  logic     sack = 1'b0, m_ack = 1'b1, seen_rise = 1'b0;
  int       bcnt = 0;

  always_comb begin
    pull = 1'b0;
    if (smode == 2 && bcnt < 8) pull = ~stx[7 - bcnt];
    else if (smode == 1 && bcnt == 8) pull = sack;
  end

  // monitor
  logic scl_m = 1'b1, sda_m = 1'b1;
  int lo_n = 0, hi_n = 0, st_n = 0, free_n = 1000;
  int last_lo = 0, last_hi = 0;
  bit after_stop = 1'b1, start_pend = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl != scl_m) chk("R4 sda steady at scl edge", int'(sda != sda_m), 0);
      if (scl && scl_m && sda_m && !sda) begin
        if (after_stop) chk_ge("R8 bus free before start", free_n, E_SU47);
        else            chk_ge("R7 repeated start setup", hi_n, E_SU47);
        after_stop = 1'b0;
        start_pend = 1'b1;
        st_n = 0;
        bcnt = 0;
        seen_rise = 1'b0;
      end else if (scl && scl_m && !sda_m && sda) begin
        chk_ge("R8 stop setup", hi_n, E_SU47);
        after_stop = 1'b1;
        free_n = 0;
      end
      if (scl && !scl_m) begin
        chk_ge("R3 low time", lo_n, E_LOW);
        last_lo = lo_n;
        lo_n = 0;
        hi_n = 0;
        seen_rise = 1'b1;
        if (bcnt < 8) srx = {srx[6:0], sda};
        else          m_ack = sda;
      end else if (!scl && scl_m) begin
        chk_ge("R3 high time", hi_n, E_HIGH);
        last_hi = hi_n;
        if (start_pend) chk_ge("R2 start hold", st_n, E_HD);
        start_pend = 1'b0;
        hi_n = 0;
        lo_n = 0;
        if (seen_rise) bcnt = (bcnt == 8) ? 0 : bcnt + 1;
        seen_rise = 1'b0;
      end
      if (scl) hi_n++; else lo_n++;
      st_n++;
      free_n++;
    end
    scl_m = scl;
    sda_m = sda;
  end

  task automatic pulse_cmd(input logic [1:0] c, input logic [7:0] d, input logic nk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wr_data = d; rd_nack = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string r);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk({r, " done seen"}, int'(done), 1);
    @(negedge clk);
    chk("R9 done lasts one cycle", int'(done), 0);
  endtask

  task automatic do_start();
    pulse_cmd(2'd0, 8'd0, 1'b0);
    wait_done("R2");
    chk("R2 lines held after start", int'({scl_oe, sda_oe}), 3);
  endtask

  task automatic do_stop();
    pulse_cmd(2'd1, 8'd0, 1'b0);
    wait_done("R8");
    chk("R8 lines free after stop", int'({scl_oe, sda_oe, busy}), 0);
  endtask

  task automatic do_write(input logic [7:0] d, input logic a);
    sack = a; smode = 1;
    pulse_cmd(2'd2, d, 1'b0);
    wait_done("R5");
    chk("R5 byte seen by slave", int'(srx), int'(d));
    chk("R5 ack reported", int'(ack_out), int'(a));
    chk("R11 exact low count", last_lo, E_LOW);
    chk("R11 exact high count", last_hi, E_HIGH);
    smode = 0;
  endtask

  task automatic do_read(input logic [7:0] d, input logic nk);
    stx = d; smode = 2;
    pulse_cmd(2'd3, 8'd0, nk);
    wait_done("R6");
    chk("R6 byte returned", int'(rd_data), int'(d));
    chk("R6 ninth bit from master", int'(m_ack), int'(nk));
    smode = 0;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int nb;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", int'({scl_oe, sda_oe, busy, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'({scl_oe, sda_oe, busy, done}), 0);

    // R10: commands on a free bus are ignored
    for (int k = 1; k <= 3; k++) begin
      pulse_cmd(2'(k), 8'h00, 1'b0);
      begin
        int seen = 0;
        repeat (40) begin
          @(negedge clk);
          if (done || scl_oe || sda_oe) seen = 1;
        end
        chk("R10 ignored on free bus", seen, 0);
      end
    end

    // directed: all-zero, all-one, NACK, busy-ignore
    do_start();
    do_write(8'h00, 1'b1);
    do_write(8'hFF, 1'b0);
    do_read(8'h81, 1'b0);
    do_read(8'h7E, 1'b1);
    do_stop();

    // R9: command during busy is ignored
    do_start();
    sack = 1'b1; smode = 1;
    pulse_cmd(2'd2, 8'hA5, 1'b0);
    repeat (20) @(negedge clk);
    chk("R9 busy during byte", int'(busy), 1);
    pulse_cmd(2'd1, 8'h00, 1'b0);
    wait_done("R9");
    chk("R9 byte unaffected", int'(srx), 8'hA5);
    smode = 0;
    repeat (30) @(negedge clk);
    chk("R9 stop during busy ignored", int'(scl_oe), 1);
    do_start();
    do_read(8'h3C, 1'b1);
    do_stop();

    // random transactions
    for (int t = 0; t < 30; t++) begin
      do_start();
      nb = 1 + int'($urandom % 4);
      for (int b = 0; b < nb; b++) begin
        if ($urandom % 2) do_write(8'($urandom), 1'($urandom));
        else              do_read(8'($urandom), (b == nb - 1) ? 1'b1 : 1'($urandom));
        if ($urandom % 6 == 0) do_start();
      end
      do_stop();
      repeat (int'($urandom % 5)) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule